// File: doc/BRIEF.md
# Buffered Matrix Multiply Core

This block forms the product of two square matrices of signed 16-bit elements. The default size is 32 by 32. A host loads both operand matrices one element at a time into two input buffers through separate write ports. Each buffer holds one full matrix. The host then releases the write enables. The core walks the operands with a single multiply-accumulate unit and produces one result element every N cycles. Each finished element goes into a result buffer with 64-bit words.

The operand read addresses are bit fields of two nested counters. An inner counter covers N*N steps and wraps. An outer counter picks the result row. The inner counter's low field is the dot-product index, and its high field is the result column. Matrix A is read by row and index, and matrix B is read by index and column. When the last element has been stored, the core raises a one-cycle data-ready pulse and returns to idle. The host then reads the results through a registered read port, and may load and start a new computation.

Top module: `mm_core`

## Requirements
- R1: After reset is released, `data_ready` is 0.
- R2: Element (r, c) of matrix A is written at `a_wr_addr = r*N + c`, and element (r, c) of matrix B at `b_wr_addr = r*N + c`. Both ports may be written in the same cycle.
- R3: Operands are two's-complement 16-bit values. Every product and the running sum are formed as signed values in 64 bits without wrap. For example, N products of -32768 by -32768 sum to N*2^30.
- R4: Result element (i, j) equals the sum over k of A(i,k)*B(k,j) and is stored at result address `i*N + j`.
- R5: A write on either input port takes the core out of idle. Computation starts at the first clock edge that then sees both write enables low. `data_ready` is 1 exactly N^3+2 cycles after that edge and 0 one cycle before.
- R6: `data_ready` is high for exactly one cycle. After it, a new load and computation may run and replaces all previous results.
- R7: `c_rd_data` shows the result word at the `c_rd_addr` value sampled on the previous rising clock edge.
- R8: While idle with no write enable asserted, no computation runs and `data_ready` stays 0.
- R9: The accumulator restarts from zero for each result element, so no term carries from one element to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_wr_en | input | 1 | Write strobe for the matrix A buffer |
| a_wr_addr | input | 2*DIM_LOG2 | Row-major element address for matrix A |
| a_wr_data | input | DATA_W | Signed element of matrix A |
| b_wr_en | input | 1 | Write strobe for the matrix B buffer |
| b_wr_addr | input | 2*DIM_LOG2 | Row-major element address for matrix B |
| b_wr_data | input | DATA_W | Signed element of matrix B |
| c_rd_addr | input | 2*DIM_LOG2 | Result read address, row-major |
| c_rd_data | output | ACC_W | Result word, one cycle after the address |
| data_ready | output | 1 | One-cycle pulse when all results are stored |

## Verification
A wrong counter field or a wrong address concatenation puts products into the wrong result cells. This shows in the first full read-back, most plainly with an identity matrix A that makes each result equal a cell of B. A sum that is not cleared, or that drops the final term, corrupts every element after the first, so any nontrivial pattern exposes it. An off-by-one in the sequencing or the write pipeline moves the data-ready pulse away from cycle N^3+2 after loading ends, and the bench checks that cycle and the cycles on either side of it. A multiply that is unsigned or too narrow shows in the all-minimum and mixed-sign patterns.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CALC = 2'd2,
    ST_DONE = 2'd3
  } mm_state_e;

endpackage

// File: rtl/mm_sdp_ram.sv
module mm_sdp_ram #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem_q[rd_addr];
  end

endmodule

// File: rtl/mm_addr_gen.sv
module mm_addr_gen #(
  parameter int DIM_LOG2 = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  output logic                  step,
  output logic [2*DIM_LOG2-1:0] a_addr,
  output logic [2*DIM_LOG2-1:0] b_addr,
  output logic [2*DIM_LOG2-1:0] c_addr,
  output logic                  last_term
);

  localparam int IW = 2 * DIM_LOG2;

  logic [IW-1:0]       inner_q, inner_d;
  logic [DIM_LOG2-1:0] outer_q, outer_d;
  logic                fin_q, fin_d;
  logic                inner_wrap;
  logic [DIM_LOG2-1:0] k_idx, j_idx;

  assign k_idx      = inner_q[DIM_LOG2-1:0];
  assign j_idx      = inner_q[IW-1:DIM_LOG2];
  assign inner_wrap = &inner_q;
  assign step       = run && !fin_q;

  assign a_addr    = {outer_q, k_idx};
  assign b_addr    = {k_idx, j_idx};
  assign c_addr    = {outer_q, j_idx};
  assign last_term = &k_idx;

  always_comb begin
    inner_d = inner_q;
    outer_d = outer_q;
    fin_d   = fin_q;
    if (!run) begin
      inner_d = '0;
      outer_d = '0;
      fin_d   = 1'b0;
    end else if (step) begin
      inner_d = inner_q + 1'b1;
      if (inner_wrap) begin
        outer_d = outer_q + 1'b1;
        if (&outer_q) begin
          fin_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_q <= '0;
      outer_q <= '0;
      fin_q   <= 1'b0;
    end else begin
      inner_q <= inner_d;
      outer_q <= outer_d;
      fin_q   <= fin_d;
    end
  end

  // R4
  outer_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && inner_wrap) |=> (outer_q == $past(outer_q) + 1'b1));

  // R4
  inner_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !inner_wrap) |=> (inner_q == $past(inner_q) + 1'b1));

endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 64,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              last_term,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              res_we,
  output logic [ADDR_W-1:0] res_waddr,
  output logic [ACC_W-1:0]  res_wdata
);

  localparam int PW = 2 * DATA_W;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    we_d;
  logic [ADDR_W-1:0]       waddr_d;
  logic [ACC_W-1:0]        wdata_d;

  assign prod     = $signed(op_a) * $signed(op_b);
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
  assign sum      = acc_q + prod_ext;

  always_comb begin
    acc_d   = acc_q;
    we_d    = 1'b0;
    waddr_d = res_waddr;
    wdata_d = res_wdata;
    if (valid) begin
      if (last_term) begin
        acc_d   = '0;
        we_d    = 1'b1;
        waddr_d = res_addr;
        wdata_d = sum;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_we    <= 1'b0;
      res_waddr <= '0;
      res_wdata <= '0;
    end else begin
      acc_q     <= acc_d;
      res_we    <= we_d;
      res_waddr <= waddr_d;
      res_wdata <= wdata_d;
    end
  end

  // R9
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && last_term) |=> (acc_q == '0));

  // R9
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> !res_we);

endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_any,
  input  logic eoc,
  output logic calc_en,
  output logic data_ready
);

  mm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (wr_any)  state_d = ST_LOAD;
      ST_LOAD: if (!wr_any) state_d = ST_CALC;
      ST_CALC: if (eoc)     state_d = ST_DONE;
      ST_DONE:              state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign calc_en    = (state_q == ST_CALC);
  assign data_ready = (state_q == ST_DONE);

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !data_ready);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !wr_any) |=> !calc_en);

endmodule

// File: rtl/mm_core.sv
module mm_core #(
  parameter int DIM_LOG2 = 5,
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_wr_en,
  input  logic [2*DIM_LOG2-1:0] a_wr_addr,
  input  logic [DATA_W-1:0]     a_wr_data,
  input  logic                  b_wr_en,
  input  logic [2*DIM_LOG2-1:0] b_wr_addr,
  input  logic [DATA_W-1:0]     b_wr_data,
  input  logic [2*DIM_LOG2-1:0] c_rd_addr,
  output logic [ACC_W-1:0]      c_rd_data,
  output logic                  data_ready
);

  localparam int AW     = 2 * DIM_LOG2;
  localparam int N_OPND = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic              opnd_we    [N_OPND];
  logic [AW-1:0]     opnd_waddr [N_OPND];
  logic [DATA_W-1:0] opnd_wdata [N_OPND];
  logic [AW-1:0]     opnd_raddr [N_OPND];
  logic [DATA_W-1:0] opnd_rdata [N_OPND];

  assign opnd_we[0]    = a_wr_en;
  assign opnd_waddr[0] = a_wr_addr;
  assign opnd_wdata[0] = a_wr_data;
  assign opnd_we[1]    = b_wr_en;
  assign opnd_waddr[1] = b_wr_addr;
  assign opnd_wdata[1] = b_wr_data;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd_buf
    mm_sdp_ram #(.WIDTH(DATA_W), .ADDR_W(AW)) u_buf (
      .clk     (clk),
      .wr_en   (opnd_we[g]),
      .wr_addr (opnd_waddr[g]),
      .wr_data (opnd_wdata[g]),
      .rd_addr (opnd_raddr[g]),
      .rd_data (opnd_rdata[g])
    );
  end

  logic          calc_en, step, last_term, eoc;
  logic [AW-1:0] a_addr, b_addr, c_addr;

  mm_addr_gen #(.DIM_LOG2(DIM_LOG2)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .run       (calc_en),
    .step      (step),
    .a_addr    (a_addr),
    .b_addr    (b_addr),
    .c_addr    (c_addr),
    .last_term (last_term)
  );

  assign opnd_raddr[0] = a_addr;
  assign opnd_raddr[1] = b_addr;

  logic          valid_q, term_q;
  logic [AW-1:0] caddr_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      term_q  <= 1'b0;
      caddr_q <= '0;
    end else begin
      valid_q <= step;
      term_q  <= step && last_term;
      if (step) begin
        caddr_q <= c_addr;
      end
    end
  end

  logic             res_we;
  logic [AW-1:0]    res_waddr;
  logic [ACC_W-1:0] res_wdata;

  mm_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .ADDR_W(AW)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .valid     (valid_q),
    .last_term (term_q),
    .res_addr  (caddr_q),
    .op_a      (opnd_rdata[0]),
    .op_b      (opnd_rdata[1]),
    .res_we    (res_we),
    .res_waddr (res_waddr),
    .res_wdata (res_wdata)
  );

  mm_sdp_ram #(.WIDTH(ACC_W), .ADDR_W(AW)) u_res_buf (
    .clk     (clk),
    .wr_en   (res_we),
    .wr_addr (res_waddr),
    .wr_data (res_wdata),
    .rd_addr (c_rd_addr),
    .rd_data (c_rd_data)
  );

  assign eoc = res_we && (&res_waddr);

  mm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_any     (a_wr_en || b_wr_en),
    .eoc        (eoc),
    .calc_en    (calc_en),
    .data_ready (data_ready)
  );

  // R5
  store_in_calc_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    res_we |-> calc_en);

  // R6
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    eoc |=> data_ready);

endmodule

// File: tb/tb_mm_core.sv
module tb_mm_core;

  localparam int L   = 3;
  localparam int N   = 1 << L;
  localparam int NN  = N * N;
  localparam int AW  = 2 * L;
  localparam int LAT = N * N * N + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_wr_en = 1'b0, b_wr_en = 1'b0;
  logic [AW-1:0] a_wr_addr = '0, b_wr_addr = '0, c_rd_addr = '0;
  logic [15:0]   a_wr_data = '0, b_wr_data = '0;
  logic [63:0]   c_rd_data;
  logic          data_ready;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  mm_core #(.DIM_LOG2(L), .DATA_W(16), .ACC_W(64)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
    .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
    .c_rd_addr(c_rd_addr), .c_rd_data(c_rd_data), .data_ready(data_ready)
  );

  function automatic int elem(int pat, int mat, int r, int c);
    case (pat)
      0: return (mat == 0) ? ((r == c) ? 1 : 0) : ((r * N + c) * 517 - 20000);
      1: return -32768;
      2: return (mat == 0) ? 32767 : -32768;
      default: return ((r * 1103 + c * 2417 + mat * 577 + r * c * 97) % 65536) - 32768;
    endcase
  endfunction

  function automatic longint expect_c(int pat, int i, int j);
    longint s = 0;
    for (int k = 0; k < N; k++) begin
      s += longint'(elem(pat, 0, i, k)) * longint'(elem(pat, 1, k, j));
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pattern(int pat, string req);
    // R2: row-major loading on both ports together
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        a_wr_en   = 1'b1;
        b_wr_en   = 1'b1;
        a_wr_addr = AW'(r * N + c);
        b_wr_addr = AW'(r * N + c);
        a_wr_data = 16'(elem(pat, 0, r, c));
        b_wr_data = 16'(elem(pat, 1, r, c));
      end
    end
    @(negedge clk);
    a_wr_en = 1'b0;
    b_wr_en = 1'b0;
    @(posedge clk);
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check(data_ready == 1'b0, "R5 ready early", longint'(data_ready), 0);
    @(negedge clk);
    check(data_ready == 1'b1, "R5 ready at N^3+2", longint'(data_ready), 1);
    @(negedge clk);
    check(data_ready == 1'b0, "R6 ready one cycle", longint'(data_ready), 0);
    // R7: pipelined read, one cycle per address
    c_rd_addr = '0;
    for (int idx = 0; idx < NN; idx++) begin
      @(negedge clk);
      check(c_rd_data == 64'(expect_c(pat, idx / N, idx % N)),
            $sformatf("%s R7 C[%0d]", req, idx),
            longint'(c_rd_data), expect_c(pat, idx / N, idx % N));
      c_rd_addr = AW'(idx + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(data_ready == 1'b0, "R1 reset", longint'(data_ready), 0);
    // R8: no writes, no computation
    for (int t = 0; t < LAT + 10; t++) begin
      @(negedge clk);
      if (data_ready) check(1'b0, "R8 idle", 1, 0);
    end
    check(data_ready == 1'b0, "R8 idle", longint'(data_ready), 0);
    run_pattern(0, "R2 R4");
    run_pattern(1, "R3");
    run_pattern(2, "R3 R6");
    run_pattern(3, "R4 R9");
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule